// File: doc/BRIEF.md
# Time-Division Switch Scheduler for Two Traffic Classes

This block schedules the crossbar of a five-port on-chip router that carries two classes of traffic. Guaranteed traffic follows a slot table. Time is cut into slots of three cycles each. For every slot and every output, the table names which input, if any, owns that output. An input that owns an output sends its staged three-flit block through the crossbar as a whole during that slot. Because the table is set up so that no two connections share an output, guaranteed connections never contend.

Best-effort traffic fills every crossbar output that the table leaves unused in a slot. An output is also left unused when its owning input has no block staged. Each output has its own matrix arbiter. When several inputs want the same free output, the least recently granted of them wins.

All decisions are made once per slot, at the slot boundary, and are held for the three cycles of the slot. The slot table is written through a simple write port, which is fed by the logic that decodes best-effort configuration packets. A write only changes decisions made at later slot boundaries.

Top module: `tdm_switch_sched`

## Requirements
- R1: After reset `slot_o` is 0 and every output and grant is 0. `slot_o` then advances by one every 3 clock cycles and wraps from 7 to 0. The first scheduled slot is slot 1, so nothing is granted during slot 0 after reset.
- R2: Take output k and slot s, where the table entry (s, k) is valid with source input j, and `gt_pend_i[j]` is 1 at the boundary into slot s. Then, for the whole of slot s:
  - `out_en_o[k]` is 1 and `out_gt_o[k]` is 1;
  - field k of `out_sel_o` (bits k*3 +: 3) equals j;
  - `gt_gnt_o[j]` is 1.
- R3: An output that carries guaranteed traffic in a slot is never given to a best-effort requester. An input that holds a guaranteed grant in a slot gets no best-effort grant in that slot.
- R4: If the table entry for output k is invalid, or its source input has no staged block, output k is offered to best-effort requests. A best-effort request is `be_req_i[i]` with field i of `be_dest_i` (bits i*3 +: 3) equal to k.
- R5: Each output arbitrates its best-effort requesters by pairwise priority. After reset a lower input index beats a higher one. The winner becomes lower in priority than every other input for that output, so the least recently granted requester wins. The winner appears as `be_gnt_o[i]`, `out_en_o[k]`=1, `out_gt_o[k]`=0 and field k of `out_sel_o` equal to i.
- R6: A table write never changes the decisions of the slot in progress. A write made during slot s to the entry of slot s+1 is used at the boundary into slot s+1.
- R7: `out_en_o`, `out_gt_o`, `out_sel_o`, `gt_gnt_o` and `be_gnt_o` change only at slot boundaries. The `out_sel_o` field of an idle output is 0.
- R8: These have no effect:
  - a table write with `cfg_out_i` or `cfg_src_i` of 5 or more;
  - a best-effort request whose destination is 5 or more.
- R9: Writing an entry with `cfg_vld_i`=0 removes the guaranteed path of that slot and output. The output is then open to best-effort traffic in that slot.
- R10: `gt_gnt_o` and `be_gnt_o` never share a set bit. The number of set bits in `be_gnt_o` equals the number of outputs that are enabled but not marked guaranteed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gt_pend_i | input | 5 | Per input: a complete guaranteed block is staged |
| be_req_i | input | 5 | Per input: a best-effort flit is waiting |
| be_dest_i | input | 15 | Per input: 3-bit destination output of the best-effort request |
| cfg_we_i | input | 1 | Slot table write strobe |
| cfg_slot_i | input | 3 | Slot index to write |
| cfg_out_i | input | 3 | Output index to write |
| cfg_vld_i | input | 1 | Entry valid bit to write |
| cfg_src_i | input | 3 | Source input index to write |
| slot_o | output | 3 | Current slot number |
| out_en_o | output | 5 | Per output: crossbar path active this slot |
| out_gt_o | output | 5 | Per output: active path carries guaranteed traffic |
| out_sel_o | output | 15 | Per output: 3-bit input index driving the crossbar |
| gt_gnt_o | output | 5 | Per input: guaranteed grant for this slot |
| be_gnt_o | output | 5 | Per input: best-effort grant for this slot |

## Verification
The checker watches the slot cadence and the wrap on every cycle. It also checks that all decisions are frozen inside a slot, that the two grant classes never overlap, and that each best-effort output has exactly one granted input. Which input wins a contested output, and which table entry drives a given output, depend on the arbitration history and on the table contents. Only the bench's scenarios can show these, by comparing against its own model of the least-recently-granted order and a mirror of the table. The timing of table writes relative to slot boundaries, and the rejection of out-of-range writes and destinations, are likewise shown only by scenario.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;
  localparam int unsigned DEF_PORTS    = 5;
  localparam int unsigned DEF_SLOTS    = 8;
  localparam int unsigned DEF_SLOT_CYC = 3;

  typedef enum logic [1:0] {
    PATH_IDLE = 2'd0,
    PATH_GT   = 2'd1,
    PATH_BE   = 2'd2
  } path_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned SLOT_CYC = 3,
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] slot_o,
  output logic [SW-1:0] next_slot_o,
  output logic          bound_o
);
  logic [CW-1:0] cyc_q;
  logic [SW-1:0] slot_q;

  assign bound_o     = (cyc_q == CW'(SLOT_CYC - 1));
  assign next_slot_o = (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
  assign slot_o      = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (bound_o) begin
      cyc_q  <= '0;
      slot_q <= next_slot_o;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter int unsigned PORTS = 5,
  parameter int unsigned SLOTS = 8,
  localparam int unsigned IW = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SW-1:0]       wr_slot_i,
  input  logic [IW-1:0]       wr_out_i,
  input  logic                wr_vld_i,
  input  logic [IW-1:0]       wr_src_i,
  input  logic [SW-1:0]       rd_slot_i,
  output logic [PORTS-1:0]    rd_vld_o,
  output logic [PORTS*IW-1:0] rd_src_o
);
  logic [PORTS-1:0] vld_q [SLOTS];
  logic [IW-1:0]    src_q [SLOTS][PORTS];
  logic             wr_ok;

  // out-of-range fields drop the whole write
  assign wr_ok = we_i && (32'(wr_out_i) < PORTS) && (32'(wr_src_i) < PORTS) &&
                 (32'(wr_slot_i) < SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(SLOTS); s++) begin
        vld_q[s] <= '0;
        for (int k = 0; k < int'(PORTS); k++) src_q[s][k] <= '0;
      end
    end else if (wr_ok) begin
      vld_q[wr_slot_i][wr_out_i] <= wr_vld_i;
      src_q[wr_slot_i][wr_out_i] <= wr_src_i;
    end
  end

  always_comb begin
    for (int k = 0; k < int'(PORTS); k++) begin
      rd_vld_o[k]         = vld_q[rd_slot_i][k];
      rd_src_o[k*IW +: IW] = src_q[rd_slot_i][k];
    end
  end
endmodule

// File: rtl/tdm_matrix_arb.sv
module tdm_matrix_arb #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         upd_i,
  output logic [N-1:0] gnt_o
);
  // pri_q[i][j] = 1: input i beats input j
  logic [N-1:0] pri_q [N];

  for (genvar i = 0; i < int'(N); i++) begin : g_win
    logic [N-1:0] self_m;
    assign self_m   = N'(1) << i;
    assign gnt_o[i] = req_i[i] & ~|(req_i & ~pri_q[i] & ~self_m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++)
        for (int j = 0; j < int'(N); j++)
          pri_q[i][j] <= (j > i);
    end else if (upd_i && |gnt_o) begin
      for (int i = 0; i < int'(N); i++)
        for (int j = 0; j < int'(N); j++)
          if (i != j) begin
            if (gnt_o[i])      pri_q[i][j] <= 1'b0;
            else if (gnt_o[j]) pri_q[i][j] <= 1'b1;
          end
    end
  end
endmodule

// File: rtl/tdm_switch_sched.sv
module tdm_switch_sched
  import tdm_sched_pkg::*;
#(
  parameter int unsigned PORTS    = DEF_PORTS,
  parameter int unsigned SLOTS    = DEF_SLOTS,
  parameter int unsigned SLOT_CYC = DEF_SLOT_CYC,
  localparam int unsigned IW = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PORTS-1:0]    gt_pend_i,
  input  logic [PORTS-1:0]    be_req_i,
  input  logic [PORTS*IW-1:0] be_dest_i,
  input  logic                cfg_we_i,
  input  logic [SW-1:0]       cfg_slot_i,
  input  logic [IW-1:0]       cfg_out_i,
  input  logic                cfg_vld_i,
  input  logic [IW-1:0]       cfg_src_i,
  output logic [SW-1:0]       slot_o,
  output logic [PORTS-1:0]    out_en_o,
  output logic [PORTS-1:0]    out_gt_o,
  output logic [PORTS*IW-1:0] out_sel_o,
  output logic [PORTS-1:0]    gt_gnt_o,
  output logic [PORTS-1:0]    be_gnt_o
);
  logic [SW-1:0]       next_slot;
  logic                bound;
  logic [PORTS-1:0]    tbl_vld;
  logic [PORTS*IW-1:0] tbl_src;

  tdm_slot_timer #(.SLOTS(SLOTS), .SLOT_CYC(SLOT_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_o     (slot_o),
    .next_slot_o(next_slot),
    .bound_o    (bound)
  );

  // decisions read the entry of the slot about to start
  tdm_slot_table #(.PORTS(PORTS), .SLOTS(SLOTS)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wr_slot_i(cfg_slot_i),
    .wr_out_i (cfg_out_i),
    .wr_vld_i (cfg_vld_i),
    .wr_src_i (cfg_src_i),
    .rd_slot_i(next_slot),
    .rd_vld_o (tbl_vld),
    .rd_src_o (tbl_src)
  );

  logic [PORTS-1:0]             gt_ok;
  logic [PORTS-1:0]             gt_claim;
  logic [PORTS-1:0][PORTS-1:0]  be_req_m;
  logic [PORTS-1:0][PORTS-1:0]  be_gnt_m;

  always_comb begin
    gt_claim = '0;
    for (int k = 0; k < int'(PORTS); k++) begin
      gt_ok[k] = tbl_vld[k] && (32'(tbl_src[k*IW +: IW]) < PORTS) &&
                 gt_pend_i[tbl_src[k*IW +: IW]];
      for (int i = 0; i < int'(PORTS); i++)
        if (gt_ok[k] && tbl_src[k*IW +: IW] == IW'(i)) gt_claim[i] = 1'b1;
    end
    for (int k = 0; k < int'(PORTS); k++)
      for (int i = 0; i < int'(PORTS); i++)
        be_req_m[k][i] = be_req_i[i] && (be_dest_i[i*IW +: IW] == IW'(k)) &&
                         !gt_claim[i] && !gt_ok[k];
  end

  for (genvar k = 0; k < int'(PORTS); k++) begin : g_arb
    tdm_matrix_arb #(.N(PORTS)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (be_req_m[k]),
      .upd_i (bound),
      .gnt_o (be_gnt_m[k])
    );
  end

  path_e               path_d [PORTS];
  path_e               path_q [PORTS];
  logic [PORTS*IW-1:0] sel_d, sel_q;
  logic [PORTS-1:0]    be_in_d, be_in_q, gt_in_q;

  always_comb begin
    sel_d   = '0;
    be_in_d = '0;
    for (int k = 0; k < int'(PORTS); k++) begin
      path_d[k] = PATH_IDLE;
      if (gt_ok[k]) begin
        path_d[k]          = PATH_GT;
        sel_d[k*IW +: IW]  = tbl_src[k*IW +: IW];
      end else if (|be_gnt_m[k]) begin
        path_d[k] = PATH_BE;
        for (int i = 0; i < int'(PORTS); i++)
          if (be_gnt_m[k][i]) sel_d[k*IW +: IW] = IW'(i);
      end
      be_in_d = be_in_d | be_gnt_m[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(PORTS); k++) path_q[k] <= PATH_IDLE;
      sel_q   <= '0;
      be_in_q <= '0;
      gt_in_q <= '0;
    end else if (bound) begin
      for (int k = 0; k < int'(PORTS); k++) path_q[k] <= path_d[k];
      sel_q   <= sel_d;
      be_in_q <= be_in_d;
      gt_in_q <= gt_claim;
    end
  end

  always_comb begin
    for (int k = 0; k < int'(PORTS); k++) begin
      out_en_o[k] = (path_q[k] != PATH_IDLE);
      out_gt_o[k] = (path_q[k] == PATH_GT);
    end
  end

  assign out_sel_o = sel_q;
  assign gt_gnt_o  = gt_in_q;
  assign be_gnt_o  = be_in_q;
endmodule

// File: rtl/tdm_switch_sched_chk.sv
module tdm_switch_sched_chk #(
  parameter int unsigned PORTS    = 5,
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned SLOT_CYC = 3,
  localparam int unsigned IW = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [SW-1:0]       slot_o,
  input logic [PORTS-1:0]    out_en_o,
  input logic [PORTS-1:0]    out_gt_o,
  input logic [PORTS*IW-1:0] out_sel_o,
  input logic [PORTS-1:0]    gt_gnt_o,
  input logic [PORTS-1:0]    be_gnt_o
);
  int unsigned ph_q;
  logic        last_cyc;

  assign last_cyc = (ph_q == SLOT_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= 0;
    else if (last_cyc) ph_q <= 0;
    else               ph_q <= ph_q + 1;
  end

  a_r1_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_cyc |=> (32'(slot_o) == ((32'($past(slot_o)) == SLOTS - 1) ? 32'd0
                                   : 32'($past(slot_o)) + 32'd1)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_cyc |=> ($stable(slot_o) && $stable(out_en_o) && $stable(out_gt_o) &&
                   $stable(out_sel_o) && $stable(gt_gnt_o) && $stable(be_gnt_o)));

  a_r10_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gt_gnt_o & be_gnt_o) == '0);

  a_r10_be_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(be_gnt_o) == $countones(out_en_o & ~out_gt_o));

  a_r2_gt_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_gt_o & ~out_en_o) == '0);

  a_r2_gt_pairing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gt_gnt_o) == (|out_gt_o));
endmodule

bind tdm_switch_sched tdm_switch_sched_chk #(
  .PORTS(PORTS), .SLOTS(SLOTS), .SLOT_CYC(SLOT_CYC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .slot_o   (slot_o),
  .out_en_o (out_en_o),
  .out_gt_o (out_gt_o),
  .out_sel_o(out_sel_o),
  .gt_gnt_o (gt_gnt_o),
  .be_gnt_o (be_gnt_o)
);

// File: tb/tdm_switch_sched_tb_top.sv
`timescale 1ns/1ps
module tdm_switch_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  gt_pend = '0, be_req = '0;
  logic [14:0] be_dest = '0;
  logic        cfg_we = 1'b0, cfg_vld = 1'b0;
  logic [2:0]  cfg_slot = '0, cfg_out = '0, cfg_src = '0;
  logic [2:0]  slot_o;
  logic [4:0]  out_en, out_gt, gt_gnt, be_gnt;
  logic [14:0] out_sel;

  always #10 clk = ~clk;

  tdm_switch_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .gt_pend_i(gt_pend), .be_req_i(be_req), .be_dest_i(be_dest),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_out_i(cfg_out),
    .cfg_vld_i(cfg_vld), .cfg_src_i(cfg_src),
    .slot_o(slot_o), .out_en_o(out_en), .out_gt_o(out_gt),
    .out_sel_o(out_sel), .gt_gnt_o(gt_gnt), .be_gnt_o(be_gnt)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [34:0] act,
                     input logic [34:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side slot tracking
  int ph = 0, bslot = 0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin ph <= 0; bslot <= 0; end
    else if (ph == 2) begin ph <= 0; bslot <= (bslot + 1) % 8; end
    else ph <= ph + 1;

  // model state
  logic       mv [8][5];
  logic [2:0] ms [8][5];
  int         ord [5][5];

  typedef struct {
    logic [2:0]  slot;
    logic [34:0] vec;
    string       tag;
  } exp_t;
  exp_t q[$];
  int   mon_cnt = 0;

  // monitor: each expected item is compared on all three cycles of its slot
  always @(negedge clk) begin
    if (rst_n && q.size() > 0 && slot_o == q[0].slot) begin
      logic [34:0] act;
      act = {out_en, out_gt, out_sel, gt_gnt, be_gnt};
      chk(act == q[0].vec, {q[0].tag, " R7"}, act, q[0].vec);
      mon_cnt++;
      if (mon_cnt == 3) begin
        void'(q.pop_front());
        mon_cnt = 0;
      end
    end
  end

  function automatic logic [14:0] dst(input int d0, d1, d2, d3, d4);
    return {3'(d4), 3'(d3), 3'(d2), 3'(d1), 3'(d0)};
  endfunction

  task automatic wr(input int s, input int o, input bit v, input int src);
    while (ph == 2) @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 3'(s); cfg_out = 3'(o); cfg_vld = v; cfg_src = 3'(src);
    if (o < 5 && src < 5) begin
      mv[s][o] = v;
      ms[s][o] = 3'(src);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_next(input int o, input bit v, input int src);
    while (ph == 2) @(negedge clk);
    wr((bslot + 1) % 8, o, v, src);
  endtask

  task automatic step(input logic [4:0] gp, input logic [4:0] br,
                      input logic [14:0] bd, input string tag);
    exp_t e;
    int ns;
    logic [4:0] en, gt, gg, bg, gok, claim;
    logic [14:0] sel;
    while (ph != 2) @(negedge clk);
    gt_pend = gp; be_req = br; be_dest = bd;
    ns = (bslot + 1) % 8;
    en = '0; gt = '0; gg = '0; bg = '0; gok = '0; claim = '0; sel = '0;
    for (int k = 0; k < 5; k++)
      if (mv[ns][k] && gp[ms[ns][k]]) begin
        gok[k] = 1'b1; en[k] = 1'b1; gt[k] = 1'b1;
        sel[k*3 +: 3] = ms[ns][k];
        claim[ms[ns][k]] = 1'b1;
      end
    gg = claim;
    for (int k = 0; k < 5; k++) begin
      int win, pos;
      win = -1; pos = -1;
      if (!gok[k])
        for (int p = 0; p < 5; p++) begin
          int i;
          i = ord[k][p];
          if (br[i] && 32'(bd[i*3 +: 3]) == k && !claim[i]) begin
            win = i; pos = p; break;
          end
        end
      if (win >= 0) begin
        en[k] = 1'b1; bg[win] = 1'b1; sel[k*3 +: 3] = 3'(win);
        for (int p = pos; p < 4; p++) ord[k][p] = ord[k][p+1];
        ord[k][4] = win;
      end
    end
    e.slot = 3'(ns);
    e.vec  = {en, gt, sel, gg, bg};
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
    chk(32'(slot_o) == ns, "R1 slot advance", 35'(slot_o), 35'(ns));
    gt_pend = '0; be_req = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int cur;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 5; k++) begin mv[s][k] = 1'b0; ms[s][k] = '0; end
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 5; p++) ord[k][p] = p;

    repeat (3) @(negedge clk);
    chk({slot_o, out_en, gt_gnt, be_gnt} == '0, "R1 reset",
        35'({slot_o, out_en, gt_gnt, be_gnt}), 35'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({slot_o, out_en, out_sel, gt_gnt, be_gnt} == '0, "R1 idle slot 0",
        35'({out_en, out_sel, gt_gnt, be_gnt}), 35'(0));

    // R5: contention on output 3 rotates; input 4 alone on output 1
    for (int n = 0; n < 4; n++)
      step(5'b00000, 5'b10111, dst(3, 3, 3, 0, 1), "R5 matrix rotation");

    // slot table: out2 <- in1 in every slot, out0 <- in3 in odd slots
    for (int s = 0; s < 8; s++) wr(s, 2, 1'b1, 1);
    for (int s = 1; s < 8; s += 2) wr(s, 0, 1'b1, 3);

    // R2/R3: GT paths claim outputs and inputs, BE fills the rest
    for (int n = 0; n < 3; n++)
      step(5'b01010, 5'b11101, dst(2, 0, 0, 4, 2), "R2 R3 gt plus be");

    // R4: entries valid but no staged block -> offered to BE
    for (int n = 0; n < 2; n++)
      step(5'b00000, 5'b10001, dst(2, 0, 0, 0, 2), "R4 unused gt entry");

    // R8: out-of-range writes and destination ignored
    wr(0, 5, 1'b1, 0);
    wr(1, 1, 1'b1, 6);
    wr(2, 7, 1'b0, 1);
    for (int n = 0; n < 8; n++)
      step(5'b11111, 5'b00101, dst(7, 0, 1, 0, 0), "R8 ignored inputs");

    // R9 with R6: clear next slot's out2 entry during the current slot
    wr_next(2, 1'b0, 0);
    step(5'b11111, 5'b00001, dst(2, 0, 0, 0, 0), "R9 R6 cleared entry");

    // R6: rewrite the current slot's entry mid-slot; effect only on its next visit
    step(5'b00001, 5'b00000, dst(0, 0, 0, 0, 0), "R6 before rewrite");
    cur = bslot;
    wr(cur, 4, 1'b1, 0);
    for (int n = 0; n < 8; n++)
      step(5'b00001, 5'b00010, dst(0, 4, 0, 0, 0), "R6 rewrite visible later");

    // R10 under heavy mixed load
    for (int n = 0; n < 4; n++)
      step(5'b11011, 5'b11111, dst(2, 3, 3, 4, 4), "R10 mixed load");

    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R1 scoreboard drained", 35'(q.size()), 35'(0));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule